// File: doc/BRIEF.md
# Multimode Interleaver Write-Address Generator

This block produces one write address per clock for a block interleaver memory. The address sequence applies two permutations in turn. The first spreads consecutive coded bits across the columns of the interleaving matrix. The second alternates the bits of each subcarrier between the more and less reliable constellation positions. A separate parameter table supplies the mode. The mode consists of the column count, the row count, a grouping class derived from the modulation and the block size. The memory and any later rotation stage sit outside this block.

The design computes no product or quotient. Counters walk a shared base sequence. The first address of each row equals the row number, and each later address in the row adds the row count. Two small one-hot rotating flags mark the current row and column position inside an s-by-s submatrix, where s is the grouping value. A multiplexer on these flags picks a signed offset that is added to the base.

A start pulse begins a block at position 0. Each cycle with the advance enable high moves to the next position. An end flag marks the last position of the block.

Top module: `ilv_wr_addr_gen`

## Requirements
- R1: After reset the generator is idle, `wrAddr` is 0 and `blockEnd` is 0.
- R2: In the cycle after `start` is high, `wrAddr` is the address of position k=0, which is 0. A start pulse during a block restarts the block at position 0. `start` has priority over `advance`.
- R3: For `grpClass` = 0 (grouping s=1, BPSK/QPSK), position k gives `wrAddr` = rows*(k mod cols) + floor(k/cols), and the offset is always 0.
- R4: For `grpClass` = 1 (s=2, 16QAM), `wrAddr` = 2*floor(i/2) + ((i + N - floor(i/rows)) mod 2), with i = rows*(k mod cols) + floor(k/cols) and N = `blockSize`. The offset added to the base is only -1, 0 or +1.
- R5: For `grpClass` = 2 (s=3, 64QAM), `wrAddr` = 3*floor(i/3) + ((i + N - floor(i/rows)) mod 3). The offset is only -2, -1, 0, +1 or +2.
- R6: `blockEnd` is high exactly while position N-1 is presented. Advancing from that position returns the generator to idle, with `wrAddr` 0 and `blockEnd` 0.
- R7: While `advance` is low and `start` is low, `wrAddr` and `blockEnd` hold their values. While idle, `advance` has no effect.
- R8: While a block is in progress, `wrAddr` is below `blockSize`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a block at position 0 |
| advance | input | 1 | Step to the next position |
| numCols | input | COL_W (5) | Matrix column count (13, 16 or 18) |
| numRows | input | ROW_W (6) | Matrix row count |
| grpClass | input | 2 | Grouping class: 0 s=1, 1 s=2, 2 s=3 |
| blockSize | input | ADDR_W (10) | Bits per block, rows*cols |
| wrAddr | output | ADDR_W (10) | Permuted write address |
| blockEnd | output | 1 | High on the last position of a block |

## Verification
The assertions check on every cycle that the selected offset stays inside the set allowed for the active grouping class. They also check that the address stays inside the block while one is running, that the address holds when neither start nor advance is asserted, and that a start leads to address 0. Whether each address equals the two-permutation formula can only be shown by the bench. The bench does this by sweeping every position of twelve modes. The bench scenarios also cover the end flag timing, the return to idle, a mid-block restart and the ignoring of advance while idle.

// File: rtl/ilv_pkg.sv
package ilv_pkg;
  typedef enum logic [1:0] {
    GRP_S1 = 2'd0,
    GRP_S2 = 2'd1,
    GRP_S3 = 2'd2
  } grp_e;

  typedef struct packed {
    logic clear;
    logic nextCol;
    logic nextRow;
  } walk_strobe_t;

  localparam int FLAG_W = 3;

  function automatic logic [FLAG_W-1:0] rotateFlag(input logic [FLAG_W-1:0] flag,
                                                   input logic [1:0] grp);
    logic [FLAG_W-1:0] res;
    case (grp)
      GRP_S2:  res = flag[0] ? 3'b010 : 3'b001;
      GRP_S3:  res = {flag[1], flag[0], flag[2]};
      default: res = 3'b001;
    endcase
    return res;
  endfunction
endpackage

// File: rtl/ilv_offset_sel.sv
module ilv_offset_sel
  import ilv_pkg::*;
(
  input  logic [1:0]        grpClass,
  input  logic [FLAG_W-1:0] rowFlag,
  input  logic [FLAG_W-1:0] colFlag,
  output logic signed [2:0] offset
);
  logic signed [2:0] offS2;
  logic signed [2:0] offS3;

  always_comb begin
    offS2 = 3'sd0;
    if (colFlag[1]) offS2 = rowFlag[0] ? 3'sd1 : -3'sd1;
  end

  always_comb begin
    offS3 = 3'sd0;
    if (rowFlag[0]) begin
      if (colFlag[1]) offS3 = 3'sd2;
      else if (colFlag[2]) offS3 = 3'sd1;
    end else if (rowFlag[1]) begin
      if (colFlag[1]) offS3 = -3'sd1;
      else if (colFlag[2]) offS3 = 3'sd1;
    end else if (rowFlag[2]) begin
      if (colFlag[1]) offS3 = -3'sd1;
      else if (colFlag[2]) offS3 = -3'sd2;
    end
  end

  always_comb begin
    case (grpClass)
      GRP_S2:  offset = offS2;
      GRP_S3:  offset = offS3;
      default: offset = 3'sd0;
    endcase
  end
endmodule

// File: rtl/ilv_addr_dp.sv
module ilv_addr_dp
  import ilv_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int ROW_W  = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  walk_strobe_t      strobe,
  input  logic [ROW_W-1:0]  numRows,
  input  logic [1:0]        grpClass,
  output logic [ADDR_W-1:0] wrAddr,
  output logic signed [2:0] offset
);
  localparam int SUM_W = ADDR_W + 1;

  logic [ADDR_W-1:0] baseAddr;
  logic [ADDR_W-1:0] rowStart;
  logic [FLAG_W-1:0] rowFlag;
  logic [FLAG_W-1:0] colFlag;
  logic [SUM_W-1:0]  sumAddr;

  always_ff @(posedge clk) begin
    if (rst || strobe.clear) begin
      baseAddr <= '0;
      rowStart <= '0;
      rowFlag  <= 3'b001;
      colFlag  <= 3'b001;
    end else if (strobe.nextRow) begin
      rowStart <= rowStart + 1'b1;
      baseAddr <= rowStart + 1'b1;
      rowFlag  <= rotateFlag(rowFlag, grpClass);
      colFlag  <= 3'b001;
    end else if (strobe.nextCol) begin
      baseAddr <= baseAddr + ADDR_W'(numRows);
      colFlag  <= rotateFlag(colFlag, grpClass);
    end
  end

  ilv_offset_sel u_off (
    .grpClass(grpClass),
    .rowFlag (rowFlag),
    .colFlag (colFlag),
    .offset  (offset)
  );

  assign sumAddr = $signed({1'b0, baseAddr}) + SUM_W'(offset);
  assign wrAddr  = sumAddr[ADDR_W-1:0];
endmodule

// File: rtl/ilv_walk_ctrl.sv
module ilv_walk_ctrl
  import ilv_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int COL_W  = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              advance,
  input  logic [COL_W-1:0]  numCols,
  input  logic [ADDR_W-1:0] blockSize,
  output walk_strobe_t      strobe,
  output logic              active,
  output logic              blockEnd
);
  logic [ADDR_W-1:0] posCnt;
  logic [COL_W-1:0]  colCnt;
  logic              rowEnd;
  logic              stepOk;

  assign rowEnd   = (colCnt == numCols - 1'b1);
  assign blockEnd = active && (posCnt == blockSize - 1'b1);
  assign stepOk   = !start && active && advance;

  always_comb begin
    strobe.clear   = start || (stepOk && blockEnd);
    strobe.nextRow = stepOk && !blockEnd && rowEnd;
    strobe.nextCol = stepOk && !blockEnd && !rowEnd;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      posCnt <= '0;
      colCnt <= '0;
    end else if (strobe.clear) begin
      active <= start;
      posCnt <= '0;
      colCnt <= '0;
    end else if (strobe.nextRow) begin
      posCnt <= posCnt + 1'b1;
      colCnt <= '0;
    end else if (strobe.nextCol) begin
      posCnt <= posCnt + 1'b1;
      colCnt <= colCnt + 1'b1;
    end
  end
endmodule

// File: rtl/ilv_wr_addr_gen.sv
module ilv_wr_addr_gen
  import ilv_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int COL_W  = 5,
  parameter int ROW_W  = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              advance,
  input  logic [COL_W-1:0]  numCols,
  input  logic [ROW_W-1:0]  numRows,
  input  logic [1:0]        grpClass,
  input  logic [ADDR_W-1:0] blockSize,
  output logic [ADDR_W-1:0] wrAddr,
  output logic              blockEnd
);
  walk_strobe_t      strobe;
  logic              active;
  logic signed [2:0] offset;

  ilv_walk_ctrl #(.ADDR_W(ADDR_W), .COL_W(COL_W)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .advance  (advance),
    .numCols  (numCols),
    .blockSize(blockSize),
    .strobe   (strobe),
    .active   (active),
    .blockEnd (blockEnd)
  );

  ilv_addr_dp #(.ADDR_W(ADDR_W), .ROW_W(ROW_W)) u_dp (
    .clk     (clk),
    .rst     (rst),
    .strobe  (strobe),
    .numRows (numRows),
    .grpClass(grpClass),
    .wrAddr  (wrAddr),
    .offset  (offset)
  );
endmodule

// File: rtl/ilv_wr_addr_gen_chk.sv
module ilv_wr_addr_gen_chk #(
  parameter int ADDR_W = 10
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic              advance,
  input logic [1:0]        grpClass,
  input logic [ADDR_W-1:0] blockSize,
  input logic [ADDR_W-1:0] wrAddr,
  input logic              blockEnd,
  input logic              active,
  input logic signed [2:0] offset
);
  a_r3_s1_no_offset: assert property (@(posedge clk) disable iff (rst)
    (grpClass == 2'd0) |-> (offset == 3'sd0));

  a_r4_s2_offset_range: assert property (@(posedge clk) disable iff (rst)
    (grpClass == 2'd1) |-> (offset >= -3'sd1 && offset <= 3'sd1));

  a_r5_s3_offset_range: assert property (@(posedge clk) disable iff (rst)
    (grpClass == 2'd2) |-> (offset >= -3'sd2 && offset <= 3'sd2));

  a_r8_addr_in_block: assert property (@(posedge clk) disable iff (rst)
    active |-> (wrAddr < blockSize));

  a_r2_start_gives_zero: assert property (@(posedge clk) disable iff (rst)
    start |=> (wrAddr == '0 && active));

  a_r7_hold_when_quiet: assert property (@(posedge clk) disable iff (rst)
    (!start && !advance) |=> ($stable(wrAddr) && $stable(blockEnd)));

  a_r6_end_goes_idle: assert property (@(posedge clk) disable iff (rst)
    (blockEnd && advance && !start) |=> (!active && !blockEnd && wrAddr == '0));
endmodule

bind ilv_wr_addr_gen ilv_wr_addr_gen_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .start    (start),
  .advance  (advance),
  .grpClass (grpClass),
  .blockSize(blockSize),
  .wrAddr   (wrAddr),
  .blockEnd (blockEnd),
  .active   (active),
  .offset   (offset)
);

// File: tb/tb_ilv_wr_addr_gen.sv
module tb_ilv_wr_addr_gen;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 10;
  localparam int COL_W  = 5;
  localparam int ROW_W  = 6;

  logic              clk = 1'b0;
  logic              rst;
  logic              start;
  logic              advance;
  logic [COL_W-1:0]  numCols;
  logic [ROW_W-1:0]  numRows;
  logic [1:0]        grpClass;
  logic [ADDR_W-1:0] blockSize;
  logic [ADDR_W-1:0] wrAddr;
  logic              blockEnd;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ilv_wr_addr_gen #(.ADDR_W(ADDR_W), .COL_W(COL_W), .ROW_W(ROW_W)) dut (
    .clk(clk), .rst(rst), .start(start), .advance(advance),
    .numCols(numCols), .numRows(numRows), .grpClass(grpClass),
    .blockSize(blockSize), .wrAddr(wrAddr), .blockEnd(blockEnd)
  );

  function automatic int expAddr(int k, int cols, int rows, int s);
    int n, i;
    n = rows * cols;
    i = rows * (k % cols) + k / cols;
    return s * (i / s) + ((i + n - (i / rows)) % s);
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic setMode(int cols, int rows, int cls);
    numCols   = COL_W'(cols);
    numRows   = ROW_W'(rows);
    grpClass  = 2'(cls);
    blockSize = ADDR_W'(rows * cols);
  endtask

  // Full sweep of one mode; assumes caller is just after a negedge.
  task automatic runMode(int cols, int rows, int cls);
    int s, n;
    string req;
    s = cls + 1;
    n = rows * cols;
    req = (cls == 0) ? "R3" : (cls == 1) ? "R4" : "R5";
    setMode(cols, rows, cls);
    start = 1'b1; advance = 1'b0;
    @(negedge clk);
    start = 1'b0; advance = 1'b1;
    for (int k = 0; k < n; k++) begin
      if (k > 0) @(negedge clk);
      check(req, wrAddr, expAddr(k, cols, rows, s));
      check("R6", blockEnd, (k == n - 1) ? 1 : 0);
      check("R8", (wrAddr < n) ? 1 : 0, 1);
    end
    @(negedge clk);
    check("R6", wrAddr, 0);
    check("R6", blockEnd, 0);
    for (int t = 0; t < 2; t++) begin
      @(negedge clk);
      check("R7", wrAddr, 0);
      check("R7", blockEnd, 0);
    end
    advance = 1'b0;
  endtask

  initial begin
    int b[4];
    int c[4];
    b = '{1, 2, 4, 6};
    c = '{0, 0, 1, 2};
    rst = 1'b1; start = 1'b0; advance = 1'b0;
    setMode(13, 4, 0);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1", wrAddr, 0);
    check("R1", blockEnd, 0);
    advance = 1'b1;
    @(negedge clk);
    check("R7", wrAddr, 0);
    advance = 1'b0;

    for (int m = 0; m < 4; m++) begin
      runMode(13, 4 * b[m], c[m]);
      runMode(18, 6 * b[m], c[m]);
      runMode(16, 3 * b[m], c[m]);
    end

    // Hold and restart in 64QAM, cols 13, rows 24
    setMode(13, 24, 2);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0; advance = 1'b1;
    for (int k = 0; k < 20; k++) @(negedge clk);
    check("R5", wrAddr, expAddr(20, 13, 24, 3));
    advance = 1'b0;
    for (int t = 0; t < 3; t++) begin
      @(negedge clk);
      check("R7", wrAddr, expAddr(20, 13, 24, 3));
      check("R7", blockEnd, 0);
    end
    start = 1'b1; advance = 1'b1;
    @(negedge clk);
    check("R2", wrAddr, 0);
    start = 1'b0;
    for (int k = 1; k < 30; k++) begin
      @(negedge clk);
      check("R2", wrAddr, expAddr(k, 13, 24, 3));
    end
    advance = 1'b0;

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule